// File: doc/BRIEF.md
# Main Output Enable and Power-Good Sequencer

This block decides when the main output rail of a supply may run and when the system is told that power is good. It takes an active-low enable request and an active-low kill request from connector pins. It also takes an input-in-range flag and two window-comparator flags, one for the main rail and one for the standby rail. It drives the main-rail enable, an active-low power-good status and an active-low input-good status. All delays are counted in ticks of a 1 ms strobe. Each default is the midpoint of its allowed window: 200 ms to turn on, 50 ms to turn off, 300 ms to power-good, 1100 ms minimum rest, 1800 ms to first input-good and 50 ms to input-good after a dip.

The enable and kill pins are first brought into the clock domain by two flip-flops. A change on either pin takes effect only after it has been stable for `DEB_TICKS` ticks. A five-state machine then sequences the main rail:

- IDLE: the rail is off.
- ARM: the turn-on delay is counting.
- RUN: the rail is on.
- DRAIN: the turn-off delay is counting and the rail is still on.
- REST: the rail is off for an enforced minimum time.

The transitions are:

- IDLE to ARM when the turn-on request is valid.
- ARM to IDLE when the request lapses.
- ARM to RUN when the delay expires.
- RUN to DRAIN when the enable request is released.
- RUN to REST, or DRAIN to REST, on kill or on loss of input-good.
- DRAIN to RUN when the enable request returns.
- DRAIN to REST when the turn-off delay expires.
- REST to IDLE when the rest time expires.

The standby rail is never controlled here, so kill touches only the main rail. The regulation comparators and the converter itself lie outside this block.

Top module: `mainrail_seq`

## Requirements
- R1: After reset, main_en is 0, pgood_n is 1 and inok_n is 1.
- R2: After reset, inok_n goes low on the START_TICKS-th tick after in_ok goes high. inok_n returns high on the first clock edge at which in_ok is low.
- R3: After inok_n has been low once, each later re-assertion takes DIP_TICKS ticks instead of START_TICKS.
- R4: A change on en_req_n or kill_n acts only after it has held for DEB_TICKS consecutive ticks. A pulse shorter than that has no effect on main_en.
- R5: Given input-good and no kill, main_en rises on the (DEB_TICKS+ON_TICKS)-th tick after en_req_n goes low. It never rises while kill is active.
- R6: main_en falls on the (DEB_TICKS+OFF_TICKS)-th tick after en_req_n goes high. If the filtered request returns before then, main_en stays high.
- R7: A filtered kill (kill_n low) turns main_en off on the next clock and keeps it off. It has no effect on inok_n.
- R8: Loss of input-good turns main_en off one clock after inok_n rises.
- R9: Once main_en falls, it stays low for REST_TICKS ticks. Only after that does a still-held request start the ON_TICKS delay again.
- R10: pgood_n goes low on the PG_TICKS-th tick during which main_en, main_ok and sb_ok have all been high. pgood_n goes high on the clock after any of them drops, and main_en is not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-cycle strobe every millisecond |
| en_req_n | input | 1 | Active-low main-output enable pin, asynchronous |
| kill_n | input | 1 | Active-low kill pin, asynchronous; removes the main output only |
| in_ok | input | 1 | Input supply within its operating range |
| main_ok | input | 1 | Main rail inside its ±7% regulation window |
| sb_ok | input | 1 | Standby rail inside its ±7% regulation window |
| main_en | output | 1 | Main converter enable |
| pgood_n | output | 1 | Active-low power-good status |
| inok_n | output | 1 | Active-low input-good status |

## Verification
The bench drives each input change right after a tick, so that every delay can be counted exactly. It checks each output one tick before and one tick after the computed edge. An off-by-one timer would turn on, turn off or report good a tick early or late. A design that skipped the rest state would bring the rail back after only ON_TICKS when kill is released or the input returns. A debouncer that latched a one-tick glitch would turn the rail on from noise. The bench also sweeps each pair of regulation flags with one rail bad. A power-good that looked only at the main rail would stay low while the standby rail is bad. Finally, the bench releases and re-requests enable inside the turn-off window; a sequencer without the DRAIN-to-RUN path would drop the rail.

// File: rtl/mainrail_pkg.sv
package mainrail_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_RUN,
        ST_DRAIN,
        ST_REST
    } seq_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/mr_pin_filter.sv
module mr_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_TICKS   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1ms,
    input  logic pin_n,
    output logic level_n
);
    localparam int CW = $clog2(DEB_TICKS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n)
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= pin_n;
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n)
                    if (!rst_n) sync_q[i] <= 1'b1;
                    else        sync_q[i] <= sync_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_n <= 1'b1;
            cnt_q   <= '0;
        end else if (synced == level_n) begin
            cnt_q <= '0;
        end else if (tick_1ms) begin
            if (cnt_q == CW'(DEB_TICKS - 1)) begin
                level_n <= synced;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4: the filtered level can only move on a tick edge
    p_moves_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1ms |=> $stable(level_n));

endmodule

// File: rtl/mr_input_good.sv
module mr_input_good #(
    parameter int START_TICKS = 1800,
    parameter int DIP_TICKS   = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1ms,
    input  logic in_ok,
    output logic inok_n
);
    localparam int CW = $clog2(((START_TICKS > DIP_TICKS) ? START_TICKS : DIP_TICKS) + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_q;
    logic          seen_q;

    assign last_q = seen_q ? CW'(DIP_TICKS - 1) : CW'(START_TICKS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inok_n <= 1'b1;
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!in_ok) begin
            inok_n <= 1'b1;
            cnt_q  <= '0;
        end else if (inok_n && tick_1ms) begin
            if (cnt_q == last_q) begin
                inok_n <= 1'b0;
                seen_q <= 1'b1;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2: input-good drops on the edge after the input leaves range
    p_inok_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ok |=> inok_n);

    // R2: input-good can only assert on a tick while the input is in range
    p_inok_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inok_n) |-> $past(tick_1ms) && $past(in_ok));

endmodule

// File: rtl/mr_power_good.sv
module mr_power_good #(
    parameter int PG_TICKS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1ms,
    input  logic main_en,
    input  logic main_ok,
    input  logic sb_ok,
    output logic pgood_n
);
    localparam int CW = $clog2(PG_TICKS + 1);

    logic [CW-1:0] cnt_q;
    logic          rails_up;

    assign rails_up = main_en && main_ok && sb_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pgood_n <= 1'b1;
            cnt_q   <= '0;
        end else if (!rails_up) begin
            pgood_n <= 1'b1;
            cnt_q   <= '0;
        end else if (pgood_n && tick_1ms) begin
            if (cnt_q == CW'(PG_TICKS - 1)) begin
                pgood_n <= 1'b0;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R10: any rail or enable loss releases power-good on the next edge
    p_pg_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_en || !main_ok || !sb_ok) |=> pgood_n);

endmodule

// File: rtl/mainrail_seq.sv
module mainrail_seq #(
    parameter int ON_TICKS    = 200,
    parameter int OFF_TICKS   = 50,
    parameter int PG_TICKS    = 300,
    parameter int REST_TICKS  = 1100,
    parameter int START_TICKS = 1800,
    parameter int DIP_TICKS   = 50,
    parameter int DEB_TICKS   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1ms,
    input  logic en_req_n,
    input  logic kill_n,
    input  logic in_ok,
    input  logic main_ok,
    input  logic sb_ok,
    output logic main_en,
    output logic pgood_n,
    output logic inok_n
);
    import mainrail_pkg::*;

    localparam int TW = $clog2(max3(ON_TICKS, OFF_TICKS, REST_TICKS) + 1);

    logic       en_lvl_n, kill_lvl_n;
    logic       en_act, kill_act, in_good, go;
    seq_state_t state_q, state_nx;
    logic [TW-1:0] tmr_q, tmr_last;
    logic       tmr_done;

    mr_pin_filter #(.SYNC_STAGES(2), .DEB_TICKS(DEB_TICKS)) u_en_filt (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
        .pin_n(en_req_n), .level_n(en_lvl_n));

    mr_pin_filter #(.SYNC_STAGES(2), .DEB_TICKS(DEB_TICKS)) u_kill_filt (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
        .pin_n(kill_n), .level_n(kill_lvl_n));

    mr_input_good #(.START_TICKS(START_TICKS), .DIP_TICKS(DIP_TICKS)) u_inok (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
        .in_ok(in_ok), .inok_n(inok_n));

    mr_power_good #(.PG_TICKS(PG_TICKS)) u_pg (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
        .main_en(main_en), .main_ok(main_ok), .sb_ok(sb_ok),
        .pgood_n(pgood_n));

    assign en_act   = !en_lvl_n;
    assign kill_act = !kill_lvl_n;
    assign in_good  = !inok_n;
    assign go       = en_act && !kill_act && in_good;

    always_comb begin
        unique case (state_q)
            ST_ARM:   tmr_last = TW'(ON_TICKS - 1);
            ST_DRAIN: tmr_last = TW'(OFF_TICKS - 1);
            ST_REST:  tmr_last = TW'(REST_TICKS - 1);
            default:  tmr_last = '0;
        endcase
    end

    assign tmr_done = tick_1ms && (tmr_q == tmr_last);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (go) state_nx = ST_ARM;
            ST_ARM:   if (!go) state_nx = ST_IDLE;
                      else if (tmr_done) state_nx = ST_RUN;
            ST_RUN:   if (kill_act || !in_good) state_nx = ST_REST;
                      else if (!en_act) state_nx = ST_DRAIN;
            ST_DRAIN: if (kill_act || !in_good) state_nx = ST_REST;
                      else if (en_act) state_nx = ST_RUN;
                      else if (tmr_done) state_nx = ST_REST;
            ST_REST:  if (tmr_done) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (state_nx != state_q) tmr_q <= '0;
            else if (tick_1ms)       tmr_q <= tmr_q + 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN, ST_DRAIN: main_en = 1'b1;
            default:          main_en = 1'b0;
        endcase
    end

    // R7: a filtered kill removes the main output on the next edge
    p_kill_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_act && main_en) |=> !main_en);

    // R8: losing input-good removes the main output on the next edge
    p_input_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_good && main_en) |=> !main_en);

    // R5: the rail rises only after a qualified request on a tick
    p_rise_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_en) |-> $past(in_good) && !$past(kill_act) && $past(tick_1ms));

endmodule

// File: tb/mainrail_seq_test.sv
`timescale 1ns/1ps
module mainrail_seq_test;
    localparam int ON = 6, OFF = 4, PG = 5, REST = 8, START = 10, DIP = 3, DEB = 2;

    logic clk = 0, rst_n = 0, tick = 0;
    logic en_req_n = 1, kill_n = 1, in_ok = 0, main_ok = 0, sb_ok = 0;
    logic main_en, pgood_n, inok_n;
    logic [1:0] tdiv = 0;
    int vectors = 0, errors = 0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd2);
    end

    mainrail_seq #(.ON_TICKS(ON), .OFF_TICKS(OFF), .PG_TICKS(PG), .REST_TICKS(REST),
                   .START_TICKS(START), .DIP_TICKS(DIP), .DEB_TICKS(DEB)) uut (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .en_req_n(en_req_n),
        .kill_n(kill_n), .in_ok(in_ok), .main_ok(main_ok), .sb_ok(sb_ok),
        .main_en(main_en), .pgood_n(pgood_n), .inok_n(inok_n));

    task automatic chk(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (tick !== 1'b1) @(posedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 main_en", main_en, 1'b0);
        chk("R1 pgood_n", pgood_n, 1'b1);
        chk("R1 inok_n", inok_n, 1'b1);
        rst_n = 1;
        main_ok = 1; sb_ok = 1;
        wait_ticks(1);

        // R2: first input-good after START ticks
        in_ok = 1;
        wait_ticks(START - 1); chk("R2 inok before", inok_n, 1'b1);
        wait_ticks(1);         chk("R2 inok at", inok_n, 1'b0);

        // R4: one-tick glitch on enable is ignored
        en_req_n = 0; wait_ticks(1); en_req_n = 1;
        wait_ticks(DEB + ON + 2); chk("R4 glitch ignored", main_en, 1'b0);

        // R5: kill held blocks turn-on
        kill_n = 0; wait_ticks(DEB + 1);
        en_req_n = 0; wait_ticks(DEB + ON + 2);
        chk("R5 kill blocks", main_en, 1'b0);
        kill_n = 1;
        wait_ticks(DEB + ON - 1); chk("R5 before on", main_en, 1'b0);
        wait_ticks(1);            chk("R5 on", main_en, 1'b1);
        chk("R7 standby side untouched", inok_n, 1'b0);

        // R10: power-good delay
        wait_ticks(PG - 1); chk("R10 pg before", pgood_n, 1'b1);
        wait_ticks(1);      chk("R10 pg at", pgood_n, 1'b0);

        // R10 sweep: each bad-rail combination releases pgood only
        for (int c = 0; c < 3; c++) begin
            wait_ticks(1);
            main_ok = c[0]; sb_ok = c[1];
            @(negedge clk);
            chk("R10 pg released", pgood_n, 1'b1);
            chk("R10 main_en kept", main_en, 1'b1);
            main_ok = 1; sb_ok = 1;
            wait_ticks(PG - 1); chk("R10 pg re before", pgood_n, 1'b1);
            wait_ticks(1);      chk("R10 pg re at", pgood_n, 1'b0);
        end

        // R6: turn-off delay
        wait_ticks(1);
        en_req_n = 1;
        wait_ticks(DEB + OFF - 1); chk("R6 before off", main_en, 1'b1);
        wait_ticks(1);             chk("R6 off", main_en, 1'b0);
        @(negedge clk);            chk("R10 pg after off", pgood_n, 1'b1);

        // R9: minimum rest, request held
        en_req_n = 0;
        wait_ticks(REST + ON - 1); chk("R9 rest holds", main_en, 1'b0);
        wait_ticks(1);             chk("R9 restart", main_en, 1'b1);
        wait_ticks(PG);            chk("R10 pg restart", pgood_n, 1'b0);

        // R6: re-request inside turn-off window keeps rail on
        en_req_n = 1; wait_ticks(2); en_req_n = 0;
        wait_ticks(OFF + 4);
        chk("R6 rail kept", main_en, 1'b1);
        chk("R6 pg kept", pgood_n, 1'b0);

        // R7: kill drops main output only
        kill_n = 0;
        wait_ticks(DEB); chk("R7 before kill", main_en, 1'b1);
        @(negedge clk);  chk("R7 killed", main_en, 1'b0);
        chk("R7 inok unaffected", inok_n, 1'b0);
        @(negedge clk);  chk("R7 pg released", pgood_n, 1'b1);
        wait_ticks(1);
        kill_n = 1;
        wait_ticks(REST - 1 + ON - 1); chk("R9 kill rest holds", main_en, 1'b0);
        wait_ticks(1);                 chk("R9 kill restart", main_en, 1'b1);
        wait_ticks(PG);                chk("R10 pg after kill", pgood_n, 1'b0);

        // R8 / R3: input dip
        in_ok = 0;
        @(negedge clk); chk("R2 inok drop", inok_n, 1'b1);
        @(negedge clk); chk("R8 rail drop", main_en, 1'b0);
        @(negedge clk); chk("R8 pg drop", pgood_n, 1'b1);
        in_ok = 1;
        wait_ticks(DIP - 1); chk("R3 dip before", inok_n, 1'b1);
        wait_ticks(1);       chk("R3 dip at", inok_n, 1'b0);
        wait_ticks(REST + ON - DIP - 1); chk("R8 rest holds", main_en, 1'b0);
        wait_ticks(1);                   chk("R8 restart", main_en, 1'b1);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule